// File: doc/BRIEF.md
# 4x4 Inverse Transform and Reconstruction

This block turns a 4x4 block of signed 16-bit transform coefficients back into pixels. A 4-point fixed-point inverse cosine transform runs on each row, then on each column of that result. The values are scaled down with rounding and added to an 8-bit prediction block. The block returns sixteen 8-bit pixels, each clamped to 0..255.

Blocks stream in one row per beat. Each beat carries four coefficients and the four prediction pixels of the same row. Results leave one reconstructed row per beat, top to bottom. Both sides use valid/ready. A transfer happens on a rising edge where valid and ready are both high. A producer that raises valid must hold its data until the transfer. While out_ready is low, the block holds out_valid and out_pix steady.

The row pass runs on the input beat, and its result is written into a one-block transpose buffer. Once that buffer holds four rows, the four column passes and the pixel stage act on the whole block together. The block moves into a row-sequenced output register as soon as that register is empty, or is about to be emptied.

Top module: `itx4_recon`

## Requirements
- R1: Each 1-D pass uses the constants 11585, 15137 and 6270. It forms a = x0+x2 and b = x0-x2, both wrapped to 16 bits. It then computes full-width products s0 = a*11585, s1 = b*11585, s2 = x1*6270 - x3*15137 and s3 = x1*15137 + x3*6270.
- R2: Each product from R1 is rounded as (p + 8192) >>> 14 and then saturated to the range -32768..32767.
- R3: Each pass outputs y0 = s0+s3, y1 = s1+s2, y2 = s1-s2 and y3 = s0-s3, with every sum wrapped to 16 bits.
- R4: The first pass runs on each coefficient row. The second pass runs on each column of the row-pass result, and its output k becomes row k of that column.
- R5: Each column-pass value v is scaled to (v + 8) >>> 4.
- R6: Each scaled value is added to the unsigned prediction pixel at the same position, and the sum is clamped to 0..255.
- R7: An input beat carries one row, and the rows of a block arrive top to bottom, four beats per block. Coefficient column k sits at in_coef[16k+15:16k] and prediction column k sits at in_pred[8k+7:8k].
- R8: After the fourth beat of a block, in_ready stays low until that block has moved into the output stage. At most one block is held between the passes.
- R9: Output rows leave top to bottom, with pixel k at out_pix[8k+7:8k]. While out_valid is high and out_ready is low, out_valid and out_pix stay unchanged.
- R10: When the last row of a block is taken and the next block is already buffered, the next block loads in the same cycle, and out_valid stays high with no idle beat.
- R11: A synchronous active-high reset clears out_valid, the row count and the buffered block, so in_ready is high after reset and a partly received block is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input row beat is valid |
| in_ready | output | 1 | Block can accept an input row |
| in_coef | input | 64 | Four signed coefficients of one row, column 0 in the low bits |
| in_pred | input | 32 | Four prediction pixels of the same row, column 0 in the low bits |
| out_valid | output | 1 | Output row beat is valid |
| out_ready | input | 1 | Consumer accepts the output row |
| out_pix | output | 32 | Four reconstructed pixels of one row, column 0 in the low bits |

## Verification
Two events can fall in the same cycle: the consumer taking the final row of one block, and the next block loading from the transpose buffer into the output register. The bench sets this up by parking one block in the output stage with out_ready low, then filling the buffer with a second block and confirming that in_ready stays low. When it releases out_ready, it requires eight back-to-back valid rows with no gap, and a reference model checks the data of both blocks row by row.

// File: rtl/itx4_pkg.sv
package itx4_pkg;
  localparam int N_PT      = 4;
  localparam int COEF_W    = 16;
  localparam int PIX_W     = 8;
  localparam int FRAC_BITS = 14;
  localparam int OUT_SHIFT = 4;
  localparam int C_PI4     = 11585;
  localparam int C_PI8     = 15137;
  localparam int C_3PI8    = 6270;
endpackage

// File: rtl/itx4_pass.sv
module itx4_pass
  import itx4_pkg::*;
#(
  parameter int W    = COEF_W,
  parameter int FRAC = FRAC_BITS
) (
  input  logic [N_PT*W-1:0] x,
  output logic [N_PT*W-1:0] y
);
  localparam int PW = 2*W + 2;
  localparam logic signed [PW-1:0] K_PI4  = PW'(C_PI4);
  localparam logic signed [PW-1:0] K_PI8  = PW'(C_PI8);
  localparam logic signed [PW-1:0] K_3PI8 = PW'(C_3PI8);
  localparam logic signed [PW-1:0] RND    = PW'(1) <<< (FRAC-1);
  localparam logic signed [PW-1:0] MAXV   = (PW'(1) <<< (W-1)) - PW'(1);
  localparam logic signed [PW-1:0] MINV   = -MAXV - PW'(1);

  logic signed [W-1:0] xv [N_PT];
  logic signed [W-1:0] sv [N_PT];
  logic signed [W-1:0] ev_sum, ev_dif;
  logic signed [PW-1:0] prod [N_PT];

  for (genvar k = 0; k < N_PT; k++) begin : g_unpack
    assign xv[k] = x[k*W +: W];
  end

  // even half wraps to W bits before the multiply
  assign ev_sum = xv[0] + xv[2];
  assign ev_dif = xv[0] - xv[2];

  assign prod[0] = PW'(ev_sum) * K_PI4;
  assign prod[1] = PW'(ev_dif) * K_PI4;
  assign prod[2] = PW'(xv[1]) * K_3PI8 - PW'(xv[3]) * K_PI8;
  assign prod[3] = PW'(xv[1]) * K_PI8  + PW'(xv[3]) * K_3PI8;

  function automatic logic signed [W-1:0] rnd_sat(input logic signed [PW-1:0] p);
    logic signed [PW-1:0] t;
    t = (p + RND) >>> FRAC;
    if (t > MAXV)      rnd_sat = MAXV[W-1:0];
    else if (t < MINV) rnd_sat = MINV[W-1:0];
    else               rnd_sat = t[W-1:0];
  endfunction

  for (genvar k = 0; k < N_PT; k++) begin : g_round
    assign sv[k] = rnd_sat(prod[k]);
  end

  // output butterfly, wrapping sums
  assign y[0*W +: W] = sv[0] + sv[3];
  assign y[1*W +: W] = sv[1] + sv[2];
  assign y[2*W +: W] = sv[1] - sv[2];
  assign y[3*W +: W] = sv[0] - sv[3];
endmodule

// File: rtl/itx4_tbuf.sv
module itx4_tbuf
  import itx4_pkg::*;
#(
  parameter int W = COEF_W,
  parameter int P = PIX_W,
  parameter int N = N_PT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [N*W-1:0]   wr_row,
  input  logic [N*P-1:0]   wr_pred,
  input  logic             drain,
  output logic             full,
  output logic [N*N*W-1:0] blk,
  output logic [N*N*P-1:0] blk_pred
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N-1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      full     <= 1'b0;
      blk      <= '0;
      blk_pred <= '0;
    end else if (wr_en) begin
      blk[cnt*N*W +: N*W]      <= wr_row;
      blk_pred[cnt*N*P +: N*P] <= wr_pred;
      if (cnt == LAST) begin
        cnt  <= '0;
        full <= 1'b1;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end else if (drain) begin
      full <= 1'b0;
    end
  end

  AST_NO_FILL_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full); // R8
  AST_FULL_UNTIL_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (full && !drain) |=> full); // R8
endmodule

// File: rtl/itx4_pixel.sv
module itx4_pixel
  import itx4_pkg::*;
#(
  parameter int W     = COEF_W,
  parameter int P     = PIX_W,
  parameter int SHIFT = OUT_SHIFT
) (
  input  logic [W-1:0] res,
  input  logic [P-1:0] pred,
  output logic [P-1:0] pix
);
  localparam logic signed [W:0]   RND  = (W+1)'(1) <<< (SHIFT-1);
  localparam logic signed [W+1:0] PMAX = (W+2)'((1 << P) - 1);

  logic signed [W:0]   wide, scaled;
  logic signed [W+1:0] sum, predw;

  assign wide   = $signed({res[W-1], res}) + RND;
  assign scaled = wide >>> SHIFT;
  assign predw  = $signed({{(W+2-P){1'b0}}, pred});
  assign sum    = (W+2)'(scaled) + predw;

  always_comb begin
    if (sum < 0)         pix = '0;
    else if (sum > PMAX) pix = PMAX[P-1:0];
    else                 pix = sum[P-1:0];
  end
endmodule

// File: rtl/itx4_obuf.sv
module itx4_obuf
  import itx4_pkg::*;
#(
  parameter int P = PIX_W,
  parameter int N = N_PT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [N*N*P-1:0] blk_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [N*P-1:0]   out_pix,
  output logic             last_pop
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N-1);

  logic [N*N*P-1:0] blk_q;
  logic [CW-1:0]    row;
  logic             pop;

  assign pop      = out_valid && out_ready;
  assign last_pop = pop && (row == LAST);
  assign out_pix  = blk_q[row*N*P +: N*P];

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q     <= '0;
      row       <= '0;
      out_valid <= 1'b0;
    end else if (load) begin
      blk_q     <= blk_in;
      row       <= '0;
      out_valid <= 1'b1;
    end else if (pop) begin
      if (row == LAST) begin
        row       <= '0;
        out_valid <= 1'b0;
      end else begin
        row <= row + CW'(1);
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix))); // R9
  AST_ROW_RUN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && row != LAST) |=> out_valid); // R9
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    load |-> (!out_valid || last_pop)); // R8
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (last_pop && load) |=> (out_valid && row == '0)); // R10
endmodule

// File: rtl/itx4_recon.sv
module itx4_recon
  import itx4_pkg::*;
#(
  parameter int W = COEF_W,
  parameter int P = PIX_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [N_PT*W-1:0]   in_coef,
  input  logic [N_PT*P-1:0]   in_pred,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [N_PT*P-1:0]   out_pix
);
  localparam int N = N_PT;

  logic [N*W-1:0]   row_res;
  logic [N*N*W-1:0] mid;
  logic [N*N*P-1:0] mid_pred;
  logic [N*N*P-1:0] recon;
  logic [N*W-1:0]   col_x [N];
  logic [N*W-1:0]   col_y [N];
  logic             full, wr_en, xfer, last_pop;

  assign in_ready = !full;
  assign wr_en    = in_valid && in_ready;
  assign xfer     = full && (!out_valid || last_pop);

  itx4_pass #(.W(W), .FRAC(FRAC_BITS)) u_rowp (.x(in_coef), .y(row_res));

  itx4_tbuf #(.W(W), .P(P), .N(N)) u_tbuf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_row(row_res), .wr_pred(in_pred),
    .drain(xfer), .full(full), .blk(mid), .blk_pred(mid_pred)
  );

  // transpose: column c gathers element c of every stored row
  for (genvar c = 0; c < N; c++) begin : g_col
    for (genvar r = 0; r < N; r++) begin : g_gather
      assign col_x[c][r*W +: W] = mid[(r*N+c)*W +: W];
    end
    itx4_pass #(.W(W), .FRAC(FRAC_BITS)) u_colp (.x(col_x[c]), .y(col_y[c]));
  end

  for (genvar r = 0; r < N; r++) begin : g_prow
    for (genvar c = 0; c < N; c++) begin : g_pcol
      itx4_pixel #(.W(W), .P(P), .SHIFT(OUT_SHIFT)) u_pix (
        .res(col_y[c][r*W +: W]),
        .pred(mid_pred[(r*N+c)*P +: P]),
        .pix(recon[(r*N+c)*P +: P])
      );
    end
  end

  itx4_obuf #(.P(P), .N(N)) u_obuf (
    .clk(clk), .rst(rst), .load(xfer), .blk_in(recon),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
    .last_pop(last_pop)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready)); // R11
endmodule

// File: tb/itx4_recon_bench.sv
module itx4_recon_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [63:0]  in_coef = '0;
  logic [31:0]  in_pred = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [31:0]  out_pix;

  int total = 0;
  int bad = 0;
  int rdy_mode = 0;   // 0 always ready, 1 random, 2 stalled
  logic [31:0] expq[$];
  logic [31:0] e_row;

  always #5 clk = ~clk;

  itx4_recon u_itx4_recon (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .in_pred(in_pred), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix)
  );

  localparam int NTV = 6;
  localparam logic [255:0] TV_COEF [NTV] = '{
    256'h0, 256'h40, 256'h8000, 256'h7fff,
    {192'h0, 64'h7fff_0000_7fff_0000}, 256'hffc0};
  localparam logic [127:0] TV_PRED [NTV] = '{
    128'h0f0e0d0c0b0a09080706050403020100, {16{8'h64}}, {16{8'hc8}},
    {16{8'h0a}}, {16{8'h80}}, {16{8'h64}}};
  localparam logic [127:0] TV_EXP [NTV] = '{
    128'h0f0e0d0c0b0a09080706050403020100, {16{8'h66}}, 128'h0,
    {16{8'hff}}, {4{32'h00ff00ff}}, {16{8'h62}}};

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---- reference model built from the requirements ----
  function automatic int rs(input longint p);
    longint t;
    t = (p + 64'sd8192) >>> 14;
    if (t > 32767) return 32767;
    if (t < -32768) return -32768;
    return int'(t);
  endfunction

  function automatic int w16(input int v);
    return int'(shortint'(v));
  endfunction

  function automatic void pass1d(input int x[4], output int y[4]);
    int a, b, s0, s1, s2, s3;
    a  = w16(x[0] + x[2]);
    b  = w16(x[0] - x[2]);
    s0 = rs(longint'(a) * 11585);
    s1 = rs(longint'(b) * 11585);
    s2 = rs(longint'(x[1]) * 6270 - longint'(x[3]) * 15137);
    s3 = rs(longint'(x[1]) * 15137 + longint'(x[3]) * 6270);
    y[0] = w16(s0 + s3);
    y[1] = w16(s1 + s2);
    y[2] = w16(s1 - s2);
    y[3] = w16(s0 - s3);
  endfunction

  function automatic logic [127:0] ref_blk(input logic [255:0] cf, input logic [127:0] pd);
    int m[4][4];
    int xi[4];
    int yo[4];
    int v;
    logic [127:0] res;
    res = '0;
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) xi[c] = int'($signed(cf[(r*4+c)*16 +: 16]));
      pass1d(xi, yo);
      for (int c = 0; c < 4; c++) m[r][c] = yo[c];
    end
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) xi[r] = m[r][c];
      pass1d(xi, yo);
      for (int r = 0; r < 4; r++) begin
        v = ((yo[r] + 8) >>> 4) + int'(pd[(r*4+c)*8 +: 8]);
        if (v < 0) v = 0;
        if (v > 255) v = 255;
        res[(r*4+c)*8 +: 8] = 8'(v);
      end
    end
    return res;
  endfunction

  // ---- drivers and monitor ----
  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = 1'($urandom_range(0, 1));
      default: out_ready = 1'b0;
    endcase
  end

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R9 unexpected output row", 64'(out_pix), 64'h0);
      end else begin
        e_row = expq.pop_front();
        chk(out_pix == e_row, "R1 R2 R3 R4 R5 R6 R7 R9 row data", 64'(out_pix), 64'(e_row));
      end
    end
  end

  task automatic send_beat(input logic [63:0] cf, input logic [31:0] pd);
    in_valid = 1'b1;
    in_coef  = cf;
    in_pred  = pd;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic push_block(input logic [255:0] cf, input logic [127:0] pd, input logic [127:0] ex);
    for (int r = 0; r < 4; r++) expq.push_back(ex[r*32 +: 32]);
    for (int r = 0; r < 4; r++) send_beat(cf[r*64 +: 64], pd[r*32 +: 32]);
  endtask

  task automatic wait_empty();
    while (expq.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0 rows pending", expq.size());
    finish_up();
  end

  initial begin
    logic [255:0] cf;
    logic [127:0] pd;
    logic [31:0]  held;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R11 out_valid after reset", 64'(out_valid), 64'h0);
    chk(in_ready, "R11 in_ready after reset", 64'(in_ready), 64'h1);

    // table of known vectors
    rdy_mode = 0;
    @(posedge clk); #1;
    for (int i = 0; i < NTV; i++) push_block(TV_COEF[i], TV_PRED[i], TV_EXP[i]);
    wait_empty();

    // R8/R10: park one block in the output stage, buffer a second
    rdy_mode = 2;
    @(posedge clk); #1;
    cf = {192'h0, 64'h0000_0000_0000_0100};
    pd = {16{8'h30}};
    push_block(cf, pd, ref_blk(cf, pd));
    repeat (3) @(negedge clk);
    chk(out_valid, "R8 block handed to output stage", 64'(out_valid), 64'h1);
    chk(in_ready, "R8 buffer free after handoff", 64'(in_ready), 64'h1);
    held = out_pix;
    @(posedge clk); #1;
    cf = {64'h0000_0000_0000_0000, 64'h0000_0000_0000_0020, 64'h0000_0000_ffa0_0000, 64'h0000_0000_0000_fe00};
    pd = 128'h80706050_40302010_f0e0d0c0_b0a09080;
    push_block(cf, pd, ref_blk(cf, pd));
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!in_ready, "R8 in_ready low while block waits", 64'(in_ready), 64'h0);
      chk(out_valid && out_pix == held, "R9 stalled row held", 64'(out_pix), 64'(held));
    end
    rdy_mode = 0;
    @(posedge clk);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(out_valid, "R10 back-to-back rows without gap", 64'(out_valid), 64'h1);
    end
    wait_empty();

    // R11: reset in the middle of a block discards the partial rows
    send_beat(64'h7fff_7fff_7fff_7fff, 32'hffff_ffff);
    send_beat(64'h8000_8000_8000_8000, 32'h0);
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R11 out_valid after mid-block reset", 64'(out_valid), 64'h0);
    chk(in_ready, "R11 in_ready after mid-block reset", 64'(in_ready), 64'h1);
    @(posedge clk); #1;
    push_block(TV_COEF[1], TV_PRED[1], TV_EXP[1]);
    wait_empty();

    // model-checked blocks with random back-pressure
    rdy_mode = 1;
    for (int b = 0; b < 24; b++) begin
      for (int n = 0; n < 16; n++) begin
        if (b % 3 == 0) cf[n*16 +: 16] = 16'($urandom);
        else            cf[n*16 +: 16] = 16'($urandom_range(0, 600) - 300);
        pd[(n % 16)*8 +: 8] = 8'($urandom);
      end
      push_block(cf, pd, ref_blk(cf, pd));
    end
    rdy_mode = 0;
    wait_empty();
    finish_up();
  end
endmodule